// File: doc/BRIEF.md
# Three-Input Bitwise Truth-Table Unit

This block applies any Boolean function of three inputs, bit by bit, to three 128-bit source operands A, B and C. The function is given as an 8-bit truth-table immediate. Every bit position is treated on its own, with no carry or shift between bits, so one immediate can stand for AND, XOR, a select, a complement, a constant or any of the other 256 three-input functions.

The caller presents the operands and the immediate together with a valid strobe. One clock later the registered result appears on the output, and the output valid flag is high for that cycle. When the strobe is low the output register keeps its last value. Immediates that give a constant, or that copy or complement a single operand, go through a small shortcut path. Every other immediate goes through a per-bit table lookup. Both paths give the same result.

Top module: `tt3_unit`

## Requirements
- R1: For every bit position i, the result bit is imm_i[7 - {a,b,c}], where a, b and c are bit i of src_a_i, src_b_i and src_c_i, and {a,b,c} is read as a 3-bit number with a as its most significant bit. Equivalently, the result is the OR, over all table positions k whose bit imm_i[7-k] is set, of the minterm (k[2]?A:~A)&(k[1]?B:~B)&(k[0]?C:~C).
- R2: imm_i = 8'h00 gives an all-zero result and imm_i = 8'hFF gives an all-ones result, for any operand values.
- R3: imm_i = 8'h0F gives A, 8'h33 gives B and 8'h55 gives C.
- R4: imm_i = 8'h03 gives A&B, 8'h3C gives A^B, 8'hF0 gives ~A, 8'h88 gives ~(B|C) and 8'h99 gives ~(B^C).
- R5: imm_i = 8'h1B gives (C?B:A) per bit, and 8'h53 gives (A?B:C) per bit.
- R6: When valid_i is high at a rising clock edge, result_o shows the result for that cycle's inputs and valid_o is high, both from that edge until the next one. When valid_i is low at an edge, valid_o is low after it.
- R7: When valid_i is low at a rising edge, result_o keeps its value, whatever the operands and immediate are.
- R8: While rst_ni is low, valid_o is 0 and result_o is all zeros. Reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe; operands and immediate are captured when high |
| imm_i | input | 8 | Truth table; table position k is bit 7-k |
| src_a_i | input | 128 | Operand A (most significant table index bit) |
| src_b_i | input | 128 | Operand B |
| src_c_i | input | 128 | Operand C (least significant table index bit) |
| valid_o | output | 1 | High in the cycle after an accepted strobe |
| result_o | output | 128 | Registered result |

## Verification
The bench goes after the index order: it checks named immediates whose results differ if the table were read LSB-first or if the roles of A and C were swapped. A design with a reversed index would turn 8'h0F into ~A and would turn the two selects into different functions. It walks all 256 immediates with random operands against a sum-of-minterms model, which catches a wrong shortcut entry that a generic-path test would miss. It also checks that the output holds while the strobe is low and clears on an asynchronous reset in the middle of a run, so a register that loads on every edge or resets synchronously shows up as a changed or late value.

// File: rtl/tt3_pkg.sv
package tt3_pkg;
  localparam int unsigned TT_W  = 8;
  localparam int unsigned IDX_W = $clog2(TT_W);

  typedef enum logic [2:0] {
    SC_GENERIC,
    SC_ZERO,
    SC_ONES,
    SC_PASS_A,
    SC_PASS_B,
    SC_PASS_C,
    SC_NOT_A
  } sc_kind_e;

  localparam logic [TT_W-1:0] IMM_ZERO   = 8'h00;
  localparam logic [TT_W-1:0] IMM_ONES   = 8'hFF;
  localparam logic [TT_W-1:0] IMM_PASS_A = 8'h0F;
  localparam logic [TT_W-1:0] IMM_PASS_B = 8'h33;
  localparam logic [TT_W-1:0] IMM_PASS_C = 8'h55;
  localparam logic [TT_W-1:0] IMM_NOT_A  = 8'hF0;
endpackage

// File: rtl/tt3_shortcut.sv
module tt3_shortcut
  import tt3_pkg::*;
#(
  parameter int unsigned WIDTH = 128
) (
  input  logic [TT_W-1:0]  imm_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output sc_kind_e         kind_o,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (imm_i)
      IMM_ZERO:   kind_o = SC_ZERO;
      IMM_ONES:   kind_o = SC_ONES;
      IMM_PASS_A: kind_o = SC_PASS_A;
      IMM_PASS_B: kind_o = SC_PASS_B;
      IMM_PASS_C: kind_o = SC_PASS_C;
      IMM_NOT_A:  kind_o = SC_NOT_A;
      default:    kind_o = SC_GENERIC;
    endcase
  end

  always_comb begin
    unique case (kind_o)
      SC_ZERO:   res_o = '0;
      SC_ONES:   res_o = '1;
      SC_PASS_A: res_o = a_i;
      SC_PASS_B: res_o = b_i;
      SC_PASS_C: res_o = c_i;
      SC_NOT_A:  res_o = ~a_i;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/tt3_lane.sv
module tt3_lane
  import tt3_pkg::*;
#(
  parameter int unsigned LANE_W = 32
) (
  input  logic [TT_W-1:0]   imm_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] c_i,
  output logic [LANE_W-1:0] res_o
);
  // table position k sits at immediate bit 7-k
  logic [TT_W-1:0] tbl_rev;

  always_comb begin
    for (int k = 0; k < TT_W; k++) tbl_rev[k] = imm_i[TT_W-1-k];
  end

  for (genvar i = 0; i < LANE_W; i++) begin : g_bit
    logic [IDX_W-1:0] idx;
    assign idx      = {a_i[i], b_i[i], c_i[i]};
    assign res_o[i] = tbl_rev[idx];
  end
endmodule

// File: rtl/tt3_unit.sv
module tt3_unit
  import tt3_pkg::*;
#(
  parameter int unsigned WIDTH  = 128,
  parameter int unsigned LANE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       imm_i,
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] src_b_i,
  input  logic [WIDTH-1:0] src_c_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int unsigned NUM_LANES = WIDTH / LANE_W;

  logic [WIDTH-1:0] table_res;
  logic [WIDTH-1:0] fast_res;
  logic [WIDTH-1:0] next_res;
  sc_kind_e         kind;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    tt3_lane #(.LANE_W(LANE_W)) i_lane (
      .imm_i (imm_i),
      .a_i   (src_a_i[l*LANE_W +: LANE_W]),
      .b_i   (src_b_i[l*LANE_W +: LANE_W]),
      .c_i   (src_c_i[l*LANE_W +: LANE_W]),
      .res_o (table_res[l*LANE_W +: LANE_W])
    );
  end

  tt3_shortcut #(.WIDTH(WIDTH)) i_shortcut (
    .imm_i  (imm_i),
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .c_i    (src_c_i),
    .kind_o (kind),
    .res_o  (fast_res)
  );

  assign next_res = (kind == SC_GENERIC) ? table_res : fast_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= next_res;
    end
  end

  // R1: shortcut path agrees with the table lookup
  a_r1_fast_matches_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind != SC_GENERIC) |-> (fast_res == table_res));

  a_r2_zero_imm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_i == 8'h00) |=> (result_o == '0));

  a_r2_ones_imm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_i == 8'hFF) |=> (&result_o));

  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

// File: tb/test_tt3_unit.sv
`timescale 1ns/1ps
module test_tt3_unit;
  localparam int W = 128;
  localparam int NT = 13;

  localparam logic [W-1:0] PA = 128'h0123456789ABCDEF_FEDCBA9876543210;
  localparam logic [W-1:0] PB = 128'hFFFF0000FFFF0000_00FF00FF00FF00FF;
  localparam logic [W-1:0] PC = 128'hAAAA5555CCCC3333_0F0F0F0FF0F0F0F0;

  localparam logic [7:0] T_IMM [NT] = '{
    8'h00, 8'hFF, 8'h0F, 8'h33, 8'h55, 8'h03, 8'h3C,
    8'hF0, 8'h88, 8'h99, 8'h1B, 8'h53, 8'h01};
  localparam logic [W-1:0] T_EXP [NT] = '{
    '0, '1, PA, PB, PC, PA & PB, PA ^ PB,
    ~PA, ~(PB | PC), ~(PB ^ PC), (PC & PB) | (~PC & PA),
    (PA & PB) | (~PA & PC), PA & PB & PC};

  logic clk_i = 1'b0;
  logic rst_ni;
  logic valid_i;
  logic [7:0] imm_i;
  logic [W-1:0] src_a_i, src_b_i, src_c_i;
  logic valid_o;
  logic [W-1:0] result_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tt3_unit i_tt3_unit (
    .clk_i, .rst_ni, .valid_i, .imm_i, .src_a_i, .src_b_i, .src_c_i,
    .valid_o, .result_o);

  function automatic logic [W-1:0] ref_fn(logic [7:0] imm, logic [W-1:0] a,
                                          logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] acc = '0;
    for (int k = 0; k < 8; k++) begin
      if (imm[7-k])
        acc |= (k[2] ? a : ~a) & (k[1] ? b : ~b) & (k[0] ? c : ~c);
    end
    return acc;
  endfunction

  function automatic string tag_of(logic [7:0] imm);
    case (imm)
      8'h00, 8'hFF:               return "R2";
      8'h0F, 8'h33, 8'h55:        return "R3";
      8'h03, 8'h3C, 8'hF0, 8'h88, 8'h99: return "R4";
      8'h1B, 8'h53:               return "R5";
      default:                    return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] imm, logic [W-1:0] a, logic [W-1:0] b,
                       logic [W-1:0] c);
    @(negedge clk_i);
    imm_i = imm; src_a_i = a; src_b_i = b; src_c_i = c; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic logic [W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    rst_ni = 1'b0; valid_i = 1'b0; imm_i = '0;
    src_a_i = '0; src_b_i = '0; src_c_i = '0;
    repeat (3) @(negedge clk_i);
    check("R8 valid", {127'b0, valid_o}, '0);
    check("R8 result", result_o, '0);
    rst_ni = 1'b1;

    // named immediates on fixed operands
    for (int t = 0; t < NT; t++) begin
      apply(T_IMM[t], PA, PB, PC);
      check(tag_of(T_IMM[t]), result_o, T_EXP[t]);
      check("R6 valid high", {127'b0, valid_o}, {127'b0, 1'b1});
    end

    // R7: idle cycle with changed inputs must not move the result
    held = result_o;
    imm_i = 8'hFF; src_a_i = ~PA;
    @(negedge clk_i);
    check("R7 hold", result_o, held);
    check("R6 valid low", {127'b0, valid_o}, '0);

    // R1: all immediates, random operands, against minterm model
    for (int i = 0; i < 256; i++) begin
      logic [W-1:0] ra, rb, rc;
      ra = rnd128(); rb = rnd128(); rc = rnd128();
      apply(i[7:0], ra, rb, rc);
      check(tag_of(i[7:0]), result_o, ref_fn(i[7:0], ra, rb, rc));
    end

    // R6: back-to-back strobes, each result a cycle later
    @(negedge clk_i);
    imm_i = 8'h3C; src_a_i = PA; src_b_i = PB; src_c_i = PC; valid_i = 1'b1;
    @(negedge clk_i);
    check("R6 b2b first", result_o, PA ^ PB);
    imm_i = 8'h88;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R6 b2b second", result_o, ~(PB | PC));

    // R8: asynchronous reset mid-run
    apply(8'hFF, PA, PB, PC);
    #1 rst_ni = 1'b0;
    #1;
    check("R8 async result", result_o, '0);
    check("R8 async valid", {127'b0, valid_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule